// File: doc/BRIEF.md
# DRAM Start-up and Refresh Scheduler

This block sits beside a DRAM access sequencer and decides when refresh cycles must be run. After a synchronous reset it waits out a start-up pause measured in clock cycles. It then asks the sequencer for a fixed number of wake-up cycles, each of which contains a row strobe. Once the last of these has been acknowledged it raises a flag that lets normal accesses through. The pause length and the refresh spacing are derived from a clock-frequency parameter.

In normal operation the block spreads refresh evenly over the retention period. The period divided by the row count gives one interval, rounded down to whole clock cycles. Each interval adds one owed refresh to a backlog counter, and every acknowledged request takes one away. A long access can therefore delay refreshes without losing any. The request line stays high while anything is owed. A sticky error flag reports that the backlog has grown past a safe depth. The refreshes are meant to be run as CAS-before-RAS cycles, in which the DRAM supplies the row from its own counter, so the block has no address output.

Top module: `dram_rfsh_sched`

## Requirements
- R1: While `rst` is high on a clock edge, `rfsh_req`, `init_done` and `backlog_err` are low after that edge. Releasing `rst` restarts the full sequence from the pause.
- R2: After `rst` is released, `rfsh_req` stays low for the pause, which is 200 µs at `CLK_HZ` rounded up to whole cycles. It first reads high after exactly that many rising edges.
- R3: After the pause, `rfsh_req` stays high. Every edge with `rfsh_req` and `rfsh_ack` both high counts as one wake-up cycle. `init_done` rises on the edge that takes the eighth such acknowledge (`INIT_CYCLES`).
- R4: An `rfsh_ack` sampled while `rfsh_req` is low has no effect: it neither counts as a wake-up cycle nor reduces the backlog.
- R5: Once `init_done` is high, one refresh is owed every `floor(CLK_HZ * 16 ms / 1024)` cycles. The first becomes owed on the edge that many cycles after `init_done` rises.
- R6: After `init_done`, `rfsh_req` is high exactly while the backlog is nonzero. An accepted acknowledge lowers the backlog by one. An interval that ends in the same cycle as an accepted acknowledge leaves the backlog unchanged.
- R7: `backlog_err` goes high on the edge where the backlog first exceeds 8 (`BACKLOG_LIMIT`). It stays high until reset.
- R8: Once high, `init_done` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rfsh_ack | input | 1 | Sequencer has taken the pending refresh or wake-up cycle |
| rfsh_req | output | 1 | A refresh or wake-up cycle is wanted |
| init_done | output | 1 | Start-up finished; normal accesses allowed |
| backlog_err | output | 1 | Sticky: owed refreshes exceeded the limit |

## Verification
The bench builds the block with `CLK_HZ` set to 5 MHz and leaves the other parameters at their defaults. This gives a 1000-cycle pause and a 78-cycle refresh interval. The short interval puts overflow of the nine-deep backlog within a few hundred cycles. It also lets one run cover the pause, the wake-up acknowledges, a long stretch of random acknowledges, a drain and a reset in the middle of operation. At 5 MHz the 16 ms / 1024 interval is not a whole number of cycles, so the bench also checks that the block rounds it down.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

   typedef enum logic [1:0] {
      PH_PAUSE = 2'd0,
      PH_INIT  = 2'd1,
      PH_RUN   = 2'd2
   } phase_e;

   function automatic longint unsigned div_ceil(input longint unsigned num,
                                                input longint unsigned den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/dram_rfsh_timer.sv
module dram_rfsh_timer #(
   parameter int unsigned PERIOD = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   output logic expire
);
   localparam int unsigned W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
   localparam logic [W-1:0] LAST = W'(PERIOD - 1);

   if (PERIOD < 2) begin : g_bad_period
      $error("dram_rfsh_timer: PERIOD must be at least 2");
   end

   logic [W-1:0] cnt;

   assign expire = en && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (rst || !en)   cnt <= '0;
      else if (expire)  cnt <= '0;
      else              cnt <= cnt + 1'b1;
   end

   // R5: no expiry can occur in the first enabled cycle
   a_r5_no_early_expire: assert property (@(posedge clk) disable iff (rst)
      !en |=> !expire);

endmodule

// File: rtl/dram_rfsh_backlog.sv
module dram_rfsh_backlog #(
   parameter int unsigned LIMIT = 8,
   parameter int unsigned W     = 6
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic tick,
   input  logic take,
   output logic pending,
   output logic overflow
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};
   localparam logic [W-1:0] LIMV = W'(LIMIT);

   if (((2 ** W) - 1) <= LIMIT) begin : g_bad_width
      $error("dram_rfsh_backlog: W too narrow to hold LIMIT+1");
   end

   logic [W-1:0] cnt, cnt_nxt;
   logic         accept;

   assign accept  = take && (cnt != '0);
   assign pending = (cnt != '0);

   always_comb begin
      cnt_nxt = cnt;
      if (!en) begin
         cnt_nxt = '0;
      end else begin
         unique case ({tick, accept})
            2'b10:   if (cnt != MAXV) cnt_nxt = cnt + 1'b1;
            2'b01:   cnt_nxt = cnt - 1'b1;
            default: cnt_nxt = cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt      <= '0;
         overflow <= 1'b0;
      end else begin
         cnt <= cnt_nxt;
         if (cnt_nxt > LIMV) overflow <= 1'b1;
      end
   end

   a_r6_tick_raises: assert property (@(posedge clk) disable iff (rst)
      en && tick && !take |=> pending);
   a_r6_idle_holds: assert property (@(posedge clk) disable iff (rst)
      en && !tick && !take |=> $stable(cnt));
   a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
      overflow |=> overflow);

endmodule

// File: rtl/dram_rfsh_sched.sv
module dram_rfsh_sched
   import dram_rfsh_pkg::*;
#(
   parameter int unsigned CLK_HZ        = 50_000_000,
   parameter int unsigned PAUSE_US      = 200,
   parameter int unsigned INIT_CYCLES   = 8,
   parameter int unsigned ROWS          = 1024,
   parameter int unsigned RETENTION_US  = 16_000,
   parameter int unsigned BACKLOG_LIMIT = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic rfsh_ack,
   output logic rfsh_req,
   output logic init_done,
   output logic backlog_err
);
   localparam longint unsigned PAUSE_L =
      div_ceil(longint'(CLK_HZ) * longint'(PAUSE_US), 64'd1_000_000);
   localparam longint unsigned INTV_L =
      (longint'(CLK_HZ) * longint'(RETENTION_US)) / (longint'(ROWS) * 64'd1_000_000);
   localparam int unsigned PAUSE_CYC = int'(PAUSE_L);
   localparam int unsigned INTV_CYC  = int'(INTV_L);
   localparam int unsigned INIT_W    = $clog2(INIT_CYCLES + 1);
   localparam int unsigned BL_W      = $clog2(BACKLOG_LIMIT + 1) + 2;
   localparam logic [INIT_W-1:0] INIT_LAST = INIT_W'(INIT_CYCLES - 1);

   if (INIT_CYCLES < 1) begin : g_bad_init
      $error("dram_rfsh_sched: INIT_CYCLES must be at least 1");
   end
   if (INTV_L < 2) begin : g_bad_interval
      $error("dram_rfsh_sched: clock too slow for the refresh interval");
   end

   phase_e            phase, phase_nxt;
   logic [INIT_W-1:0] init_cnt;
   logic              pause_end, interval_end, owed, taken;

   dram_rfsh_timer #(.PERIOD(PAUSE_CYC)) u_pause (
      .clk    (clk),
      .rst    (rst),
      .en     (phase == PH_PAUSE),
      .expire (pause_end)
   );

   dram_rfsh_timer #(.PERIOD(INTV_CYC)) u_interval (
      .clk    (clk),
      .rst    (rst),
      .en     (phase == PH_RUN),
      .expire (interval_end)
   );

   dram_rfsh_backlog #(.LIMIT(BACKLOG_LIMIT), .W(BL_W)) u_backlog (
      .clk      (clk),
      .rst      (rst),
      .en       (phase == PH_RUN),
      .tick     (interval_end),
      .take     (rfsh_ack),
      .pending  (owed),
      .overflow (backlog_err)
   );

   assign rfsh_req  = (phase == PH_INIT) || ((phase == PH_RUN) && owed);
   assign init_done = (phase == PH_RUN);
   assign taken     = rfsh_req && rfsh_ack;

   always_comb begin
      phase_nxt = phase;
      unique case (phase)
         PH_PAUSE: if (pause_end) phase_nxt = PH_INIT;
         PH_INIT:  if (taken && init_cnt == INIT_LAST) phase_nxt = PH_RUN;
         default:  phase_nxt = PH_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase    <= PH_PAUSE;
         init_cnt <= '0;
      end else begin
         phase <= phase_nxt;
         if (phase == PH_INIT && taken) init_cnt <= init_cnt + 1'b1;
      end
   end

   a_r2_quiet_pause: assert property (@(posedge clk) disable iff (rst)
      phase == PH_PAUSE |-> !rfsh_req);
   a_r3_done_on_ack: assert property (@(posedge clk) disable iff (rst)
      $rose(init_done) |-> $past(rfsh_req && rfsh_ack));
   a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
      init_done |=> init_done);
   a_r3_req_in_init: assert property (@(posedge clk) disable iff (rst)
      $rose(rfsh_req) && !init_done |-> $past(phase == PH_PAUSE));

endmodule

// File: tb/sim_dram_rfsh_sched.sv
module sim_dram_rfsh_sched;
   localparam int unsigned HZ    = 5_000_000;
   localparam int          PAUSE = (HZ / 1_000_000) * 200;
   localparam int          INTV  = ((HZ / 1000) * 16) / 1024;
   localparam int          NINIT = 8;
   localparam int          LIM   = 8;

   logic clk = 1'b0, rst = 1'b1, ack = 1'b0;
   logic req, done, err;
   int   checks = 0, errors = 0;
   bit   finished = 1'b0;

   int m_cyc, m_acks, m_k, m_bl;
   bit m_done, m_err;

   always #10 clk = ~clk;

   dram_rfsh_sched #(.CLK_HZ(HZ)) u0 (
      .clk(clk), .rst(rst), .rfsh_ack(ack),
      .rfsh_req(req), .init_done(done), .backlog_err(err)
   );

   task automatic check(input string tag, input string what,
                        input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
      end
   endtask

   task automatic check_int(input string tag, input string what,
                            input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic bit m_req();
      return (!m_done && m_cyc >= PAUSE) || (m_done && m_bl != 0);
   endfunction

   task automatic model_clear();
      m_cyc = 0; m_acks = 0; m_k = 0; m_bl = 0; m_done = 0; m_err = 0;
   endtask

   // one clock: drive ack, advance the model across the edge, compare outputs
   task automatic step(input bit a);
      bit acc, tick;
      string rtag;
      ack = a;
      acc = a && m_req();
      @(posedge clk);
      if (!m_done) begin
         if (m_cyc < PAUSE) m_cyc++;
         else if (acc) begin
            m_acks++;
            if (m_acks == NINIT) begin m_done = 1; m_k = 0; end
         end
      end else begin
         m_k++;
         tick = (m_k % INTV) == 0;
         m_bl = m_bl + int'(tick) - int'(acc);
         if (m_bl > LIM) m_err = 1;
      end
      @(negedge clk);
      ack = 1'b0;
      rtag = m_done ? "R6" : (m_cyc < PAUSE ? "R2" : "R3");
      check(rtag, "rfsh_req", req, m_req());
      check(m_done ? "R8" : "R3", "init_done", done, m_done);
      check("R7", "backlog_err", err, m_err);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; ack = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", "rfsh_req after reset", req, 1'b0);
      check("R1", "init_done after reset", done, 1'b0);
      check("R1", "backlog_err after reset", err, 1'b0);
      rst = 1'b0;
      model_clear();
   endtask

   initial begin
      repeat (200_000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL R3 watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int first_req, k, since;
      void'($urandom(32'h5eed_0042));
      model_clear();
      do_reset();

      // pause: random ack must be ignored (R4), req rises after PAUSE edges (R2)
      first_req = -1;
      for (int i = 0; i < PAUSE + 2; i++) begin
         step(($urandom % 4) == 0);
         if (req && first_req < 0) first_req = i + 1;
      end
      check_int("R2", "edges until first request", first_req, PAUSE);
      check_int("R4", "wake-up acks counted during pause", m_acks, 0);

      // wake-up cycles with random acknowledge timing (R3)
      k = 0;
      while (!m_done && k < 400) begin
         step(($urandom % 2) == 0);
         k++;
      end
      check("R3", "init_done after eighth ack", done, 1'b1);

      // acks with nothing owed are ignored; first interval lands on time (R4, R5)
      since = m_k;
      for (int i = 0; i < 10; i++) step(1'b1);
      while (!req && m_k < 4 * INTV) step(1'b0);
      check_int("R5", "cycles from init_done to first refresh", m_k - since, INTV);
      check("R4", "early acks did not make backlog negative", req, 1'b1);
      step(1'b1);
      check("R6", "single ack clears one owed refresh", req, 1'b0);

      // random acknowledge traffic (R6)
      for (int i = 0; i < 2000; i++) step(($urandom % 3) == 0);

      // drain, then starve to overflow (R7)
      for (int i = 0; i < 20; i++) step(1'b1);
      check("R7", "no error before starvation", err, 1'b0);
      for (int i = 0; i < 10 * INTV; i++) step(1'b0);
      check("R7", "error after backlog passes limit", err, 1'b1);
      for (int i = 0; i < 20; i++) step(1'b1);
      check("R6", "request low after drain", req, 1'b0);
      check("R7", "error stays after drain", err, 1'b1);

      // reset in operation restarts everything (R1)
      do_reset();
      for (int i = 0; i < 50; i++) step(1'b1);
      check("R1", "no request shortly after restart", req, 1'b0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule